// File: doc/BRIEF.md
# NAND Small-Page Operation Sequencer

This block turns a single operation request into the full, ordered series of flash bus cycles for a small-page NAND device. The request names an operation, a 24-bit byte offset, a length and six error-correction bytes. The supported operations are page read, full-page program, spare-area program and block erase. The block then issues command, address, write and read cycles one per clock. It waits for the device's ready line between phases, moves data between its byte streams and the device, reads back the device status where the operation needs it, and ends with a one-cycle completion pulse carrying a 2-bit result. The error-correction bytes are computed elsewhere; this block only places them after the page data.

Each flash cycle appears on `cyc_vld`, `cyc_kind` and `cyc_byte`. A read cycle samples `fl_rdata` in the same clock. Program data enters through a valid/ready stream and is never dropped. Read data leaves on `dout_valid`/`dout_data`, one byte per read cycle. The address bytes are, in order, offset bits 7:0, 16:9 and 23:17; bit 8 is never sent as an address bit, because it selects the half-page read command instead. Erase sends only the last two of these bytes.

The controller has these states: IDLE, RD_CMD, RST_CMD, PTR_CMD, SEQ_CMD, ERA_CMD, ADDR, WAIT, WDATA, ECC, MARK, PROG_CMD, ERA_GO, STAT_CMD, STAT_RD, RD_DATA and DONE. The transitions are as follows.
- IDLE moves on `start` to DONE when the arguments are rejected.
- Otherwise it moves to RD_CMD (read), to RST_CMD (page or spare program) or to ERA_CMD (erase).
- RST_CMD goes to WAIT, then to PTR_CMD, then to SEQ_CMD, then to ADDR.
- RD_CMD and ERA_CMD each go to ADDR.
- After its last byte, ADDR goes to WAIT and then RD_DATA (read), or to WAIT and then WDATA (page program), or straight to WDATA (spare), or to ERA_GO (erase).
- WDATA goes to ECC and then MARK for a page program, and to PROG_CMD for a spare program.
- MARK goes to PROG_CMD.
- PROG_CMD and ERA_GO each go to WAIT, then to STAT_CMD, then to STAT_RD, then to DONE.
- RD_DATA goes to DONE after its last byte.
- WAIT goes to DONE on timeout.
- DONE goes to IDLE.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `busy`, `done`, `cyc_vld`, `din_ready` and `dout_valid` are all 0.
- R2: A read (op 0) issues command 0x00 when offset bit 8 is 0 and 0x01 when it is 1. Three address bytes follow: offset[7:0], offset[16:9] and offset[23:17]. Cycle kinds are 0 command, 1 address, 2 write, 3 read.
- R3: A read cycle begins only after the ready line has been seen high, and never less than SETTLE+1 cycles after the last address byte.
- R4: A read returns min(length, 512 − offset[8:0]) bytes on `dout_data`, one per read cycle, so that it never crosses a 512-byte boundary, and then completes with result 00. Length 0 is rejected.
- R5: A page program (op 1) whose offset[8:0] is not 0, or whose length is not 512, completes one cycle after `start` with result 10 and drives no flash cycle.
- R6: A page program issues, in order: 0xFF, a wait, 0x00, 0x80, three address bytes, a wait, 512 data bytes, the six ECC bytes (bits 7:0 first), 0x55, 0x55, 0x10, a wait, 0x70 and one status read.
- R7: While `din_ready` is high and `din_valid` is low, no flash cycle is driven. Every accepted input byte appears exactly once, in order.
- R8: An erase (op 3) issues 0x60, then the address bytes offset[16:9] and offset[23:17], then 0xD0, a wait, 0x70 and one status read.
- R9: After a program or erase, result is 01 if bit 0 of the status byte is 1, and 00 otherwise.
- R10: A spare program (op 2, length 1..16) issues 0xFF, a wait, 0x50, 0x80, three address bytes, the data bytes with no wait before them, 0x10, a wait, 0x70 and a status read. No ECC or marker bytes are sent.
- R11: Any operation whose offset is at or beyond DEV_BYTES completes with result 10 and no flash cycle.
- R12: If the ready line stays low for TIMEOUT cycles after the settle period of any wait, the operation ends with result 11.
- R13: `done` is a one-cycle pulse, and `busy` stays high from the cycle after `start` until `done`. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| op | input | 2 | 0 read, 1 page program, 2 spare program, 3 erase |
| offset | input | 24 | Byte offset of the operation |
| length | input | 10 | Byte count (read, page or spare program) |
| ecc_bytes | input | 48 | Six ECC bytes appended to a page program |
| din_valid | input | 1 | Program data byte valid |
| din_data | input | 8 | Program data byte |
| din_ready | output | 1 | Sequencer accepts program data |
| dout_valid | output | 1 | Read data byte valid |
| dout_data | output | 8 | Read data byte |
| cyc_vld | output | 1 | A flash cycle is issued this clock |
| cyc_kind | output | 2 | Cycle kind: command, address, write, read |
| cyc_byte | output | 8 | Byte driven in command, address or write cycles |
| fl_rdy | input | 1 | Device ready line |
| fl_rdata | input | 8 | Byte returned by the device in read cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 device fail, 10 bad argument, 11 timeout |

## Verification
The bench targets the read clipping at the half-page and page edges. A design that ignored offset bit 8 would send the wrong read command, and one that did not clip would stream past the boundary. It also targets stalls in the program stream. A sequencer that advanced without a valid byte would emit a stale byte, or lose one, and the recorded cycle log would no longer match. Misaligned, short and out-of-range requests are sent to show that no flash cycle leaks out of a rejected operation. The bench also holds the ready line low to show the timeout code, sets status bit 0 to show the failure code, and pulses `start` during a program to show the request is ignored rather than corrupting the sequence.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SPARE = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CK_CMD  = 2'd0,
        CK_ADDR = 2'd1,
        CK_WR   = 2'd2,
        CK_RD   = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DEVFAIL = 2'd1,
        RES_BADARG  = 2'd2,
        RES_TIMEOUT = 2'd3
    } res_e;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_CMD, S_RST_CMD, S_PTR_CMD, S_SEQ_CMD, S_ERA_CMD,
        S_ADDR, S_WAIT, S_WDATA, S_ECC, S_MARK, S_PROG_CMD, S_ERA_GO,
        S_STAT_CMD, S_STAT_RD, S_RD_DATA, S_DONE
    } seq_state_e;

    localparam int unsigned PAGE_BYTES = 512;
    localparam int unsigned COL_BITS   = 9;

    localparam logic [7:0] CMD_READ_LO   = 8'h00;
    localparam logic [7:0] CMD_READ_HI   = 8'h01;
    localparam logic [7:0] CMD_SPARE_PTR = 8'h50;
    localparam logic [7:0] CMD_SEQ_IN    = 8'h80;
    localparam logic [7:0] CMD_PROG_GO   = 8'h10;
    localparam logic [7:0] CMD_RESET     = 8'hFF;
    localparam logic [7:0] CMD_ERA_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERA_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] MARK_BYTE     = 8'h55;

endpackage

// File: rtl/nand_arg_check.sv
module nand_arg_check
    import nand_seq_pkg::*;
#(
    parameter int unsigned DEV_BYTES   = 32'h0040_0000,
    parameter int unsigned SPARE_BYTES = 16,
    parameter int unsigned LEN_W       = 10
) (
    input  op_e              op,
    input  logic [23:0]      ofs,
    input  logic [LEN_W-1:0] len,
    output logic             reject,
    output logic [LEN_W-1:0] eff_len
);
    localparam logic [LEN_W-1:0] PAGE_LEN  = LEN_W'(PAGE_BYTES);
    localparam logic [LEN_W-1:0] SPARE_LEN = LEN_W'(SPARE_BYTES);

    logic             out_of_range;
    logic [LEN_W-1:0] room;

    always_comb begin
        out_of_range = {8'd0, ofs} >= DEV_BYTES;
        room         = PAGE_LEN - LEN_W'(ofs[COL_BITS-1:0]);
        reject       = out_of_range;
        eff_len      = len;
        unique case (op)
            OP_READ: begin
                reject  = out_of_range || (len == '0);
                eff_len = (len < room) ? len : room;
            end
            OP_PROG: begin
                reject  = out_of_range || (ofs[COL_BITS-1:0] != '0) || (len != PAGE_LEN);
                eff_len = PAGE_LEN;
            end
            OP_SPARE: begin
                reject  = out_of_range || (len == '0) || (len > SPARE_LEN);
                eff_len = len;
            end
            OP_ERASE: begin
                reject  = out_of_range;
                eff_len = '0;
            end
            default: begin
                reject  = 1'b1;
                eff_len = '0;
            end
        endcase
    end
endmodule

// File: rtl/nand_addr_mux.sv
module nand_addr_mux
    import nand_seq_pkg::*;
(
    input  logic [23:0] ofs,
    input  logic        two_byte,
    input  logic [1:0]  idx,
    output logic [7:0]  addr_byte
);
    logic [1:0] slot;

    always_comb begin
        slot = two_byte ? (idx + 2'd1) : idx;
        unique case (slot)
            2'd0:    addr_byte = ofs[7:0];
            2'd1:    addr_byte = ofs[COL_BITS +: 8];
            2'd2:    addr_byte = {1'b0, ofs[23:COL_BITS+8]};
            default: addr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_ready_timer.sv
module nand_ready_timer #(
    parameter int unsigned SETTLE  = 2,
    parameter int unsigned TIMEOUT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fl_rdy,
    output logic hit,
    output logic expired
);
    localparam int unsigned LIMIT = SETTLE + TIMEOUT;
    localparam int unsigned CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!active)         cnt <= '0;
        else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign hit     = active && (cnt >= CW'(SETTLE)) && fl_rdy;
    assign expired = active && (cnt == CW'(LIMIT)) && !hit;
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int unsigned LEN_W     = 10,
    parameter int unsigned ECC_BYTES = 6,
    parameter int unsigned MARK_CNT  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  op_e                    op_in,
    input  logic [23:0]            ofs_in,
    input  logic [LEN_W-1:0]       eff_len,
    input  logic                   reject,
    input  logic [8*ECC_BYTES-1:0] ecc_in,
    input  logic                   din_valid,
    input  logic [7:0]             din_data,
    input  logic [7:0]             fl_rdata,
    input  logic                   wait_hit,
    input  logic                   wait_expired,
    input  logic [7:0]             addr_byte,
    output logic [23:0]            ofs_q,
    output logic [1:0]             addr_idx,
    output logic                   two_byte,
    output logic                   wait_active,
    output logic                   din_ready,
    output logic                   dout_valid,
    output logic                   cyc_vld,
    output logic [1:0]             cyc_kind,
    output logic [7:0]             cyc_byte,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             result
);
    localparam logic [LEN_W-1:0] ECC_LAST  = LEN_W'(ECC_BYTES - 1);
    localparam logic [LEN_W-1:0] MARK_LAST = LEN_W'(MARK_CNT - 1);

    seq_state_e             state, state_n, ret_q, ret_n;
    op_e                    op_q;
    logic [LEN_W-1:0]       len_q, cnt;
    logic [8*ECC_BYTES-1:0] ecc_q;
    res_e                   res_q, res_n;
    logic                   cnt_inc, last_addr, accept;
    logic [7:0]             ecc_sel;
    logic [7:0]             ecc_arr [ECC_BYTES];

    for (genvar g = 0; g < ECC_BYTES; g++) begin : g_ecc
        assign ecc_arr[g] = ecc_q[8*g +: 8];
    end

    always_comb begin
        ecc_sel = 8'h00;
        for (int i = 0; i < ECC_BYTES; i++)
            if (cnt == LEN_W'(i)) ecc_sel = ecc_arr[i];
    end

    assign two_byte  = (op_q == OP_ERASE);
    assign addr_idx  = cnt[1:0];
    assign last_addr = two_byte ? (cnt == LEN_W'(1)) : (cnt == LEN_W'(2));
    assign accept    = (state == S_IDLE) && start;

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ret_q <= S_IDLE;
            op_q  <= OP_READ;
            ofs_q <= '0;
            len_q <= '0;
            ecc_q <= '0;
            cnt   <= '0;
            res_q <= RES_OK;
        end else begin
            state <= state_n;
            ret_q <= ret_n;
            res_q <= res_n;
            if (accept) begin
                op_q  <= op_in;
                ofs_q <= ofs_in;
                len_q <= eff_len;
                ecc_q <= ecc_in;
            end
            if (state_n != state) cnt <= '0;
            else if (cnt_inc)     cnt <= cnt + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        ret_n   = ret_q;
        res_n   = res_q;
        cnt_inc = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (reject) begin
                        res_n   = RES_BADARG;
                        state_n = S_DONE;
                    end else begin
                        unique case (op_in)
                            OP_READ:  state_n = S_RD_CMD;
                            OP_ERASE: state_n = S_ERA_CMD;
                            default:  state_n = S_RST_CMD;
                        endcase
                    end
                end
            end
            S_RST_CMD: begin
                state_n = S_WAIT;
                ret_n   = S_PTR_CMD;
            end
            S_PTR_CMD: state_n = S_SEQ_CMD;
            S_SEQ_CMD: state_n = S_ADDR;
            S_RD_CMD:  state_n = S_ADDR;
            S_ERA_CMD: state_n = S_ADDR;
            S_ADDR: begin
                cnt_inc = 1'b1;
                if (last_addr) begin
                    unique case (op_q)
                        OP_READ: begin
                            state_n = S_WAIT;
                            ret_n   = S_RD_DATA;
                        end
                        OP_PROG: begin
                            state_n = S_WAIT;
                            ret_n   = S_WDATA;
                        end
                        OP_SPARE: state_n = S_WDATA;
                        default:  state_n = S_ERA_GO;
                    endcase
                end
            end
            S_WAIT: begin
                if (wait_hit) begin
                    state_n = ret_q;
                end else if (wait_expired) begin
                    res_n   = RES_TIMEOUT;
                    state_n = S_DONE;
                end
            end
            S_WDATA: begin
                if (din_valid) begin
                    cnt_inc = 1'b1;
                    if (cnt == len_q - 1'b1)
                        state_n = (op_q == OP_PROG) ? S_ECC : S_PROG_CMD;
                end
            end
            S_ECC: begin
                cnt_inc = 1'b1;
                if (cnt == ECC_LAST) state_n = S_MARK;
            end
            S_MARK: begin
                cnt_inc = 1'b1;
                if (cnt == MARK_LAST) state_n = S_PROG_CMD;
            end
            S_PROG_CMD, S_ERA_GO: begin
                state_n = S_WAIT;
                ret_n   = S_STAT_CMD;
            end
            S_STAT_CMD: state_n = S_STAT_RD;
            S_STAT_RD: begin
                res_n   = fl_rdata[0] ? RES_DEVFAIL : RES_OK;
                state_n = S_DONE;
            end
            S_RD_DATA: begin
                cnt_inc = 1'b1;
                if (cnt == len_q - 1'b1) begin
                    res_n   = RES_OK;
                    state_n = S_DONE;
                end
            end
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cyc_vld     = 1'b0;
        cyc_kind    = CK_CMD;
        cyc_byte    = 8'h00;
        din_ready   = 1'b0;
        dout_valid  = 1'b0;
        wait_active = 1'b0;
        unique case (state)
            S_RD_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = ofs_q[COL_BITS-1] ? CMD_READ_HI : CMD_READ_LO;
            end
            S_RST_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_RESET;
            end
            S_PTR_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = (op_q == OP_SPARE) ? CMD_SPARE_PTR : CMD_READ_LO;
            end
            S_SEQ_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_SEQ_IN;
            end
            S_ERA_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_ERA_SETUP;
            end
            S_ADDR: begin
                cyc_vld  = 1'b1;
                cyc_kind = CK_ADDR;
                cyc_byte = addr_byte;
            end
            S_WAIT: wait_active = 1'b1;
            S_WDATA: begin
                din_ready = 1'b1;
                cyc_vld   = din_valid;
                cyc_kind  = CK_WR;
                cyc_byte  = din_data;
            end
            S_ECC: begin
                cyc_vld  = 1'b1;
                cyc_kind = CK_WR;
                cyc_byte = ecc_sel;
            end
            S_MARK: begin
                cyc_vld  = 1'b1;
                cyc_kind = CK_WR;
                cyc_byte = MARK_BYTE;
            end
            S_PROG_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_PROG_GO;
            end
            S_ERA_GO: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_ERA_GO;
            end
            S_STAT_CMD: begin
                cyc_vld  = 1'b1;
                cyc_byte = CMD_STATUS;
            end
            S_STAT_RD: begin
                cyc_vld  = 1'b1;
                cyc_kind = CK_RD;
            end
            S_RD_DATA: begin
                cyc_vld    = 1'b1;
                cyc_kind   = CK_RD;
                dout_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign done   = (state == S_DONE);
    assign result = res_q;
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned DEV_BYTES   = 32'h0040_0000,
    parameter int unsigned SPARE_BYTES = 16,
    parameter int unsigned ECC_BYTES   = 6,
    parameter int unsigned MARK_CNT    = 2,
    parameter int unsigned SETTLE      = 2,
    parameter int unsigned TIMEOUT     = 200,
    parameter int unsigned LEN_W       = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             op,
    input  logic [23:0]            offset,
    input  logic [LEN_W-1:0]       length,
    input  logic [8*ECC_BYTES-1:0] ecc_bytes,
    input  logic                   din_valid,
    input  logic [7:0]             din_data,
    output logic                   din_ready,
    output logic                   dout_valid,
    output logic [7:0]             dout_data,
    output logic                   cyc_vld,
    output logic [1:0]             cyc_kind,
    output logic [7:0]             cyc_byte,
    input  logic                   fl_rdy,
    input  logic [7:0]             fl_rdata,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             result
);
    op_e              op_c;
    logic             reject, two_byte, wait_active, wait_hit, wait_expired;
    logic [LEN_W-1:0] eff_len;
    logic [23:0]      ofs_q;
    logic [1:0]       addr_idx;
    logic [7:0]       addr_byte;

    assign op_c      = op_e'(op);
    assign dout_data = fl_rdata;

    nand_arg_check #(
        .DEV_BYTES  (DEV_BYTES),
        .SPARE_BYTES(SPARE_BYTES),
        .LEN_W      (LEN_W)
    ) u_arg (
        .op     (op_c),
        .ofs    (offset),
        .len    (length),
        .reject (reject),
        .eff_len(eff_len)
    );

    nand_ready_timer #(
        .SETTLE (SETTLE),
        .TIMEOUT(TIMEOUT)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (wait_active),
        .fl_rdy (fl_rdy),
        .hit    (wait_hit),
        .expired(wait_expired)
    );

    nand_addr_mux u_amux (
        .ofs      (ofs_q),
        .two_byte (two_byte),
        .idx      (addr_idx),
        .addr_byte(addr_byte)
    );

    nand_seq_fsm #(
        .LEN_W    (LEN_W),
        .ECC_BYTES(ECC_BYTES),
        .MARK_CNT (MARK_CNT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_in       (op_c),
        .ofs_in      (offset),
        .eff_len     (eff_len),
        .reject      (reject),
        .ecc_in      (ecc_bytes),
        .din_valid   (din_valid),
        .din_data    (din_data),
        .fl_rdata    (fl_rdata),
        .wait_hit    (wait_hit),
        .wait_expired(wait_expired),
        .addr_byte   (addr_byte),
        .ofs_q       (ofs_q),
        .addr_idx    (addr_idx),
        .two_byte    (two_byte),
        .wait_active (wait_active),
        .din_ready   (din_ready),
        .dout_valid  (dout_valid),
        .cyc_vld     (cyc_vld),
        .cyc_kind    (cyc_kind),
        .cyc_byte    (cyc_byte),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       din_valid,
    input logic       din_ready,
    input logic       dout_valid,
    input logic       cyc_vld,
    input logic [1:0] cyc_kind,
    input logic       fl_rdy,
    input logic       busy,
    input logic       done,
    input logic [1:0] result
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cyc_vld && !din_ready && !dout_valid));

    p_rd_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && cyc_kind == 2'd3) |-> $past(fl_rdy));

    p_dout_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (cyc_vld && cyc_kind == 2'd3));

    p_badarg_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> ($past(start) && !$past(busy)));

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && !din_valid) |-> !cyc_vld);

    p_timeout_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd3) |-> !$past(fl_rdy));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind nand_page_seq nand_page_seq_chk u_chk (.*);

// File: tb/nand_page_seq_tb.sv
module nand_page_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEV       = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [23:0] offset = '0;
    logic [9:0]  length = '0;
    logic [47:0] ecc_bytes = '0;
    logic        din_valid = 1'b0;
    logic [7:0]  din_data = '0;
    logic        din_ready, dout_valid, cyc_vld, busy, done;
    logic [7:0]  dout_data, cyc_byte;
    logic [1:0]  cyc_kind, result;
    logic        fl_rdy;
    logic [7:0]  fl_rdata;

    nand_page_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .offset(offset),
        .length(length), .ecc_bytes(ecc_bytes), .din_valid(din_valid),
        .din_data(din_data), .din_ready(din_ready), .dout_valid(dout_valid),
        .dout_data(dout_data), .cyc_vld(cyc_vld), .cyc_kind(cyc_kind),
        .cyc_byte(cyc_byte), .fl_rdy(fl_rdy), .fl_rdata(fl_rdata),
        .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // flash model and stream state (single writer)
    logic        arm = 1'b0, hang = 1'b0, feed_en = 1'b0, nogap = 1'b0;
    logic [7:0]  stat_val = '0, rseed = '0, wseed = '0;
    int          bsy_len = 0;
    int          busy_cnt, rdcnt, addr_cnt, wr_idx, n_log, n_dout, cyc_no;
    logic [7:0]  last_cmd;
    logic [9:0]  log_e [0:1023];
    int          log_t [0:1023];
    logic [7:0]  dcap  [0:1023];
    logic [9:0]  exp_e [0:1023];
    int          n_exp;

    assign fl_rdy   = !hang && (busy_cnt == 0);
    assign fl_rdata = (last_cmd == 8'h70) ? stat_val : (rseed ^ rdcnt[7:0]);

    always @(posedge clk) begin
        cyc_no <= cyc_no + 1;
        if (!rst_n || arm) begin
            busy_cnt <= 0; rdcnt <= 0; addr_cnt <= 0; wr_idx <= 0;
            n_log <= 0; n_dout <= 0; last_cmd <= 8'h00;
        end else begin
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (din_valid && din_ready) wr_idx <= wr_idx + 1;
            if (dout_valid) begin
                dcap[n_dout] <= dout_data;
                n_dout <= n_dout + 1;
            end
            if (cyc_vld) begin
                log_e[n_log] <= {cyc_kind, cyc_byte};
                log_t[n_log] <= cyc_no;
                n_log <= n_log + 1;
                if (cyc_kind == 2'd0) begin
                    last_cmd <= cyc_byte;
                    addr_cnt <= 0;
                    rdcnt    <= 0;
                    if (cyc_byte == 8'hFF || cyc_byte == 8'h10 || cyc_byte == 8'hD0)
                        busy_cnt <= bsy_len;
                end else if (cyc_kind == 2'd1) begin
                    addr_cnt <= addr_cnt + 1;
                    if (addr_cnt == 2 && (last_cmd == 8'h00 || last_cmd == 8'h01))
                        busy_cnt <= bsy_len;
                end else if (cyc_kind == 2'd3) begin
                    rdcnt <= rdcnt + 1;
                end
            end
        end
    end

    initial cyc_no = 0;

    function automatic logic [7:0] wpat(input int k);
        return 8'(int'(wseed) + 7 * k);
    endfunction

    // data feeder, drives at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            din_valid = feed_en && (nogap || (($urandom % 4) != 0));
            din_data  = wpat(wr_idx);
        end
    end

    task automatic push(input int k, input logic [7:0] b);
        exp_e[n_exp] = {2'(k), b};
        n_exp++;
    endtask

    task automatic push_addr3(input logic [23:0] a);
        push(1, a[7:0]); push(1, a[16:9]); push(1, {1'b0, a[23:17]});
    endtask

    function automatic bit rejects(input int o, input logic [23:0] a, input int len);
        bit oor = (int'(a) >= DEV);
        case (o)
            0: return oor || len == 0;
            1: return oor || a[8:0] != 0 || len != 512;
            2: return oor || len == 0 || len > 16;
            default: return oor;
        endcase
    endfunction

    function automatic int clip(input logic [23:0] a, input int len);
        int room = 512 - int'(a[8:0]);
        return (len < room) ? len : room;
    endfunction

    task automatic build_exp(input int o, input logic [23:0] a, input int len, input logic [47:0] e);
        n_exp = 0;
        if (rejects(o, a, len)) return;
        case (o)
            0: begin
                push(0, a[8] ? 8'h01 : 8'h00); push_addr3(a);
                for (int k = 0; k < clip(a, len); k++) push(3, 8'h00);
            end
            1: begin
                push(0, 8'hFF); push(0, 8'h00); push(0, 8'h80); push_addr3(a);
                for (int k = 0; k < 512; k++) push(2, wpat(k));
                for (int k = 0; k < 6; k++) push(2, e[8*k +: 8]);
                push(2, 8'h55); push(2, 8'h55);
                push(0, 8'h10); push(0, 8'h70); push(3, 8'h00);
            end
            2: begin
                push(0, 8'hFF); push(0, 8'h50); push(0, 8'h80); push_addr3(a);
                for (int k = 0; k < len; k++) push(2, wpat(k));
                push(0, 8'h10); push(0, 8'h70); push(3, 8'h00);
            end
            default: begin
                push(0, 8'h60); push(1, a[16:9]); push(1, {1'b0, a[23:17]});
                push(0, 8'hD0); push(0, 8'h70); push(3, 8'h00);
            end
        endcase
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, expv, expv);
        end
    endtask

    // one operation; poke re-pulses start while busy
    task automatic run_op(input int o, input logic [23:0] a, input int len, input logic [7:0] st,
                          input int bsy, input bit hng, input bit poke, input string req);
        logic [47:0] e;
        int exp_res, w, mism, gap, first_rd, last_ad;
        e = {$urandom, $urandom};
        @(negedge clk);
        stat_val = st; bsy_len = bsy; hang = hng; rseed = 8'($urandom); wseed = 8'($urandom);
        nogap = 1'b0; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0; feed_en = 1'b1;
        op = 2'(o); offset = a; length = 10'(len); ecc_bytes = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 5000) begin
            if (poke && w == 5) begin start = 1'b1; op = 2'd3; offset = '0; end
            else start = 1'b0;
            @(negedge clk);
            w++;
        end
        start = 1'b0;
        check(done == 1'b1, "R13", "done seen", int'(done), 1);
        if (rejects(o, a, len))          exp_res = 2;
        else if (hng)                    exp_res = 3;
        else if (o == 0)                 exp_res = 0;
        else                             exp_res = st[0] ? 1 : 0;
        check(int'(result) == exp_res, req, "result", int'(result), exp_res);
        if (!hng) begin
            build_exp(o, a, len, e);
            mism = -1;
            for (int k = 0; k < n_exp && k < n_log; k++)
                if (mism < 0 && log_e[k] != exp_e[k] && exp_e[k][9:8] != 2'd3) mism = k;
            check(n_log == n_exp, req, "cycle count", n_log, n_exp);
            if (mism >= 0)
                check(1'b0, req, "cycle entry {kind,byte}", int'(log_e[mism]), int'(exp_e[mism]));
            else
                check(1'b1, req, "cycle entries", 0, 0);
            if (o == 0 && exp_res == 0) begin
                mism = -1;
                for (int k = 0; k < n_dout; k++)
                    if (mism < 0 && dcap[k] != (rseed ^ 8'(k))) mism = k;
                check(n_dout == clip(a, len), "R4", "read byte count", n_dout, clip(a, len));
                check(mism < 0, "R4", "read data index", mism, -1);
                first_rd = -1; last_ad = 0;
                for (int k = 0; k < n_log; k++) begin
                    if (log_e[k][9:8] == 2'd1) last_ad = log_t[k];
                    if (first_rd < 0 && log_e[k][9:8] == 2'd3) first_rd = log_t[k];
                end
                gap = first_rd - last_ad;
                check(gap > bsy && gap > 2, "R3", "addr-to-data gap", gap, bsy + 3);
            end
        end
        @(negedge clk);
        check(!busy && !done, "R13", "idle after done", int'(busy) + 2 * int'(done), 0);
        feed_en = 1'b0; hang = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        check(!busy && !done && !cyc_vld && !din_ready && !dout_valid, "R1", "reset outputs",
              int'({busy, done, cyc_vld, din_ready, dout_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !cyc_vld, "R1", "idle after reset", int'({busy, cyc_vld}), 0);

        run_op(0, 24'h012040, 64, 8'h00, 3, 0, 0, "R2");
        run_op(0, 24'h0A3180, 300, 8'h00, 5, 0, 0, "R2");   // bit 8 set, clipped to 128
        run_op(0, 24'h0001FF, 5, 8'h00, 0, 0, 0, "R4");     // one byte left in page
        run_op(0, 24'h000000, 600, 8'h00, 1, 0, 0, "R4");   // clipped to 512
        run_op(0, 24'h000100, 0, 8'h00, 1, 0, 0, "R4");     // zero length rejected
        run_op(1, 24'h123400, 512, 8'h00, 4, 0, 0, "R6");
        run_op(1, 24'h002200, 512, 8'h01, 2, 0, 0, "R9");
        run_op(1, 24'h000010, 512, 8'h00, 0, 0, 0, "R5");
        run_op(1, 24'h000200, 511, 8'h00, 0, 0, 0, "R5");
        run_op(3, 24'h3FE000, 0, 8'h00, 6, 0, 0, "R8");
        run_op(3, 24'h004000, 0, 8'hE1, 1, 0, 0, "R9");
        run_op(2, 24'h000205, 16, 8'h00, 2, 0, 0, "R10");
        run_op(2, 24'h000200, 17, 8'h00, 2, 0, 0, "R10");   // too long, rejected
        run_op(0, 24'h400000, 10, 8'h00, 0, 0, 0, "R11");
        run_op(3, 24'hFFFFFF, 0, 8'h00, 0, 0, 0, "R11");
        run_op(1, 24'h000400, 512, 8'h00, 0, 1, 0, "R12");
        run_op(0, 24'h000400, 20, 8'h00, 0, 1, 0, "R12");
        run_op(1, 24'h000600, 512, 8'h00, 3, 0, 1, "R13");  // start while busy ignored

        for (int i = 0; i < 30; i++) begin
            int o, len;
            logic [23:0] a;
            o = int'($urandom % 4);
            a = 24'($urandom % 32'h0048_0000);
            case (o)
                0: len = 1 + int'($urandom % 600);
                1: begin
                    if (($urandom % 5) != 0) a[8:0] = '0;
                    len = (($urandom % 5) != 0) ? 512 : int'($urandom % 1024);
                end
                2: len = int'($urandom % 20);
                default: len = 0;
            endcase
            run_op(o, a, len, 8'($urandom), int'($urandom % 6), 0, 0, "R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL R13 watchdog: actual 0 expected 1 (run did not finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule